// File: doc/BRIEF.md
# Mode-Selectable Inverting Registered Transceiver

This block moves an 8-bit word in two directions between a split A side (a separate input bus and output bus) and a shared B side. Each direction has its own storage element. A two-bit selector makes that element a plain buffer, an edge-captured register or a level-sensitive latch. Both directions invert their data. A loopback switch can feed the stored A-to-B value, taken before inversion, into the B-to-A element. This gives a path for checking the transceiver without touching the shared bus.

Everything runs on one system clock. The per-direction strobe inputs are sampled on that clock. In register mode, a strobe sampled high after being sampled low counts as a capture. In latch mode, the strobe is an active-high transparency enable. The B side is modelled as an open-collector bus: the block drives a per-bit pull-low vector and reads the wired bus value back on a separate input. The A output drive enable and the B activity flag are derived from three enable inputs. Both elements keep loading and holding data whatever the enables say.

Top module: `xcvr_modal`

## Requirements
- R1: A synchronous reset clears both stored values and both strobe histories to 0. After reset, with both directions in register mode and no capture, `a_out` reads 8'hFF and `b_pull` reads 8'h00.
- R2: Mode 2'b00 selects buffer behaviour. The element passes its input through in the same cycle and its stored value is left unchanged.
- R3: Mode 2'b01 selects register behaviour. The element stores its input at a clock edge where the strobe is high and was low at the previous edge. It shows the stored value from the cycle after that edge, and holds it at every other edge.
- R4: Mode 2'b10 or 2'b11 selects latch behaviour. While the strobe is high, the element passes its input in the same cycle and stores it at each clock edge. While the strobe is low, it shows the value stored at the last edge where the strobe was high.
- R5: Data is inverted on both paths. `a_out` is the bitwise inverse of the B-to-A element value. Bit i of `b_pull` is 1 (pulls the bus low) only when the B side is active and bit i of the A-to-B element value is 1, meaning the inverted output bit is 0.
- R6: When `loop_en` is 1, the B-to-A element takes the A-to-B element value (before inversion) as its input. When `loop_en` is 0, it takes `b_in`.
- R7: `a_out_en` equals `a_oe`. When it is 0 the A output bus is to be treated as high-impedance.
- R8: `b_active` is 1 only when `b_oe` is 1 and `b_oe_n` is 0. When it is 0, `b_pull` is all zeros, so every bus bit is released and reads 1.
- R9: Both elements capture and hold data while their outputs are disabled or inactive. A value captured while the B side is inactive appears on `b_pull` once the B side is enabled.
- R10: The two directions are independent. Strobe activity in one direction does not alter the value stored in the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; strobes and reset are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ab_mode | input | 2 | A-to-B element mode: 00 buffer, 01 register, 1x latch |
| ba_mode | input | 2 | B-to-A element mode: 00 buffer, 01 register, 1x latch |
| ab_strobe | input | 1 | A-to-B capture strobe or latch enable |
| ba_strobe | input | 1 | B-to-A capture strobe or latch enable |
| loop_en | input | 1 | Routes the A-to-B element value into the B-to-A element |
| a_oe | input | 1 | A output bus enable, active high |
| b_oe | input | 1 | B bus enable, active high |
| b_oe_n | input | 1 | B bus enable, active low |
| a_in | input | 8 | A side input bus |
| b_in | input | 8 | Wired B bus value as observed |
| a_out | output | 8 | A side output data |
| a_out_en | output | 1 | A output drive enable |
| b_pull | output | 8 | Per-bit pull-low request onto the B bus |
| b_active | output | 1 | B side active flag |

## Verification
The hardest situation to reach from the ports is a mode change with stored state in flight. An example is a latch that closes and is then switched to register mode while its strobe stays high, so that no new rising edge may be seen. Another is loopback active while the A-to-B element is open as a latch. The stimulus sweeps every pairing of the two mode selectors, loopback and the three enables without a reset in between. Each pairing is driven with pseudo-random strobes and data, so stored values and strobe histories carry across every kind of mode switch. A bench model built from the requirements predicts every output on every cycle.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic [1:0] {
    KIND_BUF = 2'd0,
    KIND_REG = 2'd1,
    KIND_LAT = 2'd2
  } elem_kind_e;

  // 00 buffer, 01 edge register, 1x transparent latch
  function automatic elem_kind_e kind_of(input logic [1:0] sel);
    if (sel[1])      return KIND_LAT;
    else if (sel[0]) return KIND_REG;
    else             return KIND_BUF;
  endfunction

  // store new data at this clock edge?
  function automatic logic takes_new(input elem_kind_e k, input logic level,
                                     input logic level_q);
    case (k)
      KIND_REG: return level & ~level_q;
      KIND_LAT: return level;
      default:  return 1'b0;
    endcase
  endfunction

  // does the live input reach the element output this cycle?
  function automatic logic passes_live(input elem_kind_e k, input logic level);
    case (k)
      KIND_BUF: return 1'b1;
      KIND_LAT: return level;
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/xcvr_elem.sv
module xcvr_elem
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   mode_sel,
  input  logic         strobe,
  input  logic [W-1:0] din,
  output logic [W-1:0] pval,
  output logic         load_evt
);

  elem_kind_e   kind;
  logic         strobe_q;
  logic [W-1:0] hold_q;
  logic         live;

  assign kind     = kind_of(mode_sel);
  assign load_evt = takes_new(kind, strobe, strobe_q);
  assign live     = passes_live(kind, strobe);
  assign pval     = live ? din : hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= 1'b0;
      hold_q   <= '0;
    end else begin
      strobe_q <= strobe;
      if (load_evt) hold_q <= din;
    end
  end

  AST_REG_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'b01 && strobe && !strobe_q) |=> (mode_sel != 2'b01 || pval == $past(din))); // R3
  AST_REG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'b01 && !(strobe && !strobe_q)) |=> $stable(hold_q)); // R3
  AST_LAT_OPEN: assert property (@(posedge clk) disable iff (rst)
    (mode_sel[1] && strobe) |=> (hold_q == $past(din))); // R4
  AST_LAT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mode_sel[1] && !strobe) |=> $stable(hold_q)); // R4
  AST_BUF_NOSTORE: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'b00) |=> $stable(hold_q)); // R2

endmodule

// File: rtl/xcvr_oe_ctrl.sv
module xcvr_oe_ctrl (
  input  logic a_oe,
  input  logic b_oe,
  input  logic b_oe_n,
  output logic a_out_en,
  output logic b_active
);

  assign a_out_en = a_oe;
  assign b_active = b_oe & ~b_oe_n;

endmodule

// File: rtl/xcvr_outstage.sv
module xcvr_outstage #(
  parameter int W = 8
) (
  input  logic         b_active,
  input  logic [W-1:0] p_ab,
  input  logic [W-1:0] p_ba,
  output logic [W-1:0] a_out,
  output logic [W-1:0] b_pull
);

  logic [W-1:0] b_drive_inv;

  assign b_drive_inv = ~p_ab;
  assign a_out       = ~p_ba;

  // open-collector: a bit pulls low only when active and its inverted level is 0
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign b_pull[i] = b_active & ~b_drive_inv[i];
  end

endmodule

// File: rtl/xcvr_modal.sv
module xcvr_modal #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   ab_mode,
  input  logic [1:0]   ba_mode,
  input  logic         ab_strobe,
  input  logic         ba_strobe,
  input  logic         loop_en,
  input  logic         a_oe,
  input  logic         b_oe,
  input  logic         b_oe_n,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_out,
  output logic         a_out_en,
  output logic [W-1:0] b_pull,
  output logic         b_active
);

  logic [W-1:0] p_ab;
  logic [W-1:0] p_ba;
  logic [W-1:0] ba_src;
  logic         ab_load;
  logic         ba_load;

  xcvr_elem #(.W(W)) u_ab (
    .clk(clk), .rst(rst), .mode_sel(ab_mode), .strobe(ab_strobe),
    .din(a_in), .pval(p_ab), .load_evt(ab_load)
  );

  assign ba_src = loop_en ? p_ab : b_in;

  xcvr_elem #(.W(W)) u_ba (
    .clk(clk), .rst(rst), .mode_sel(ba_mode), .strobe(ba_strobe),
    .din(ba_src), .pval(p_ba), .load_evt(ba_load)
  );

  xcvr_oe_ctrl u_oe (
    .a_oe(a_oe), .b_oe(b_oe), .b_oe_n(b_oe_n),
    .a_out_en(a_out_en), .b_active(b_active)
  );

  xcvr_outstage #(.W(W)) u_out (
    .b_active(b_active), .p_ab(p_ab), .p_ba(p_ba),
    .a_out(a_out), .b_pull(b_pull)
  );

  AST_B_RELEASED: assert property (@(posedge clk) disable iff (rst)
    !b_active |-> (b_pull == '0)); // R8
  AST_INVERT_BUF: assert property (@(posedge clk) disable iff (rst)
    (b_active && ab_mode == 2'b00) |-> (b_pull == a_in)); // R5
  AST_LOOP_BUF: assert property (@(posedge clk) disable iff (rst)
    (loop_en && ba_mode == 2'b00) |-> (a_out == ~p_ab)); // R6
  AST_A_ENABLE: assert property (@(posedge clk) disable iff (rst)
    a_out_en == a_oe); // R7
  AST_STORE_WHILE_OFF: assert property (@(posedge clk) disable iff (rst)
    (!b_active && ab_load) |=> (ab_mode != 2'b01 || p_ab == $past(a_in))); // R9
  AST_DIR_INDEPENDENT: assert property (@(posedge clk) disable iff (rst)
    (ba_mode == 2'b01 && !ba_load && ab_load) |=> (ba_mode != 2'b01 || $stable(a_out) || $changed(ba_mode))); // R10

endmodule

// File: tb/xcvr_modal_tb.sv
module xcvr_modal_tb;

  logic       clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst;
  logic [1:0] ab_mode, ba_mode;
  logic       ab_strobe, ba_strobe, loop_en, a_oe, b_oe, b_oe_n;
  logic [7:0] a_in, b_ext;
  wire  [7:0] b_in;
  logic [7:0] a_out, b_pull;
  logic       a_out_en, b_active;

  assign b_in = b_ext & ~b_pull;

  xcvr_modal u_dut (
    .clk(clk), .rst(rst), .ab_mode(ab_mode), .ba_mode(ba_mode),
    .ab_strobe(ab_strobe), .ba_strobe(ba_strobe), .loop_en(loop_en),
    .a_oe(a_oe), .b_oe(b_oe), .b_oe_n(b_oe_n), .a_in(a_in), .b_in(b_in),
    .a_out(a_out), .a_out_en(a_out_en), .b_pull(b_pull), .b_active(b_active)
  );

  int   checks = 0;
  int   fails  = 0;
  bit   done   = 0;
  logic [7:0] m_ab_st, m_ba_st;
  logic m_ab_prev, m_ba_prev;
  logic [15:0] lf = 16'hACE1;

  function automatic logic [7:0] view(input logic [1:0] md, input logic str,
                                     input logic [7:0] d, input logic [7:0] st);
    if (md == 2'b00) return d;
    if (md == 2'b01) return st;
    return str ? d : st;
  endfunction

  task automatic calc(output logic [7:0] pab, output logic [7:0] bsrc,
                      output logic [7:0] pba, output logic [7:0] pull,
                      output logic act);
    pab  = view(ab_mode, ab_strobe, a_in, m_ab_st);
    act  = b_oe && !b_oe_n;
    pull = act ? pab : 8'h00;
    bsrc = loop_en ? pab : (b_ext & ~pull);
    pba  = view(ba_mode, ba_strobe, bsrc, m_ba_st);
  endtask

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string mode_tag(input logic [1:0] md);
    if (md == 2'b00) return "R2 buffer";
    if (md == 2'b01) return "R3 register";
    return "R4 latch";
  endfunction

  task automatic compare_all();
    logic [7:0] pab, bsrc, pba, pull;
    logic act;
    #1;
    calc(pab, bsrc, pba, pull, act);
    check8(loop_en ? "R6 loopback a_out" : {"R5 a_out ", mode_tag(ba_mode)}, a_out, ~pba);
    check8("R7 a_out_en", {7'd0, a_out_en}, {7'd0, a_oe});
    check8("R8 b_active", {7'd0, b_active}, {7'd0, act});
    check8(act ? {"R5 b_pull ", mode_tag(ab_mode)} : "R8 b_pull released", b_pull, pull);
  endtask

  task automatic tick();
    logic [7:0] pab, bsrc, pba, pull;
    logic act;
    @(posedge clk);
    calc(pab, bsrc, pba, pull, act);
    if (rst) begin
      m_ab_st = 8'h00; m_ba_st = 8'h00; m_ab_prev = 1'b0; m_ba_prev = 1'b0;
    end else begin
      if ((ab_mode == 2'b01 && ab_strobe && !m_ab_prev) || (ab_mode[1] && ab_strobe))
        m_ab_st = a_in;
      if ((ba_mode == 2'b01 && ba_strobe && !m_ba_prev) || (ba_mode[1] && ba_strobe))
        m_ba_st = bsrc;
      m_ab_prev = ab_strobe;
      m_ba_prev = ba_strobe;
    end
    @(negedge clk);
  endtask

  task automatic step();
    compare_all();
    tick();
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
  end

  initial begin
    rst = 1; ab_mode = 2'b01; ba_mode = 2'b01; ab_strobe = 0; ba_strobe = 0;
    loop_en = 0; a_oe = 1; b_oe = 1; b_oe_n = 0; a_in = 8'hAA; b_ext = 8'hFF;
    m_ab_st = 0; m_ba_st = 0; m_ab_prev = 0; m_ba_prev = 0;
    @(negedge clk);
    repeat (3) tick();
    rst = 0;
    #1;
    check8("R1 reset a_out", a_out, 8'hFF);
    check8("R1 reset b_pull", b_pull, 8'h00);
    tick();

    // R9: capture while the B side is inactive, then enable it
    ab_mode = 2'b01; b_oe = 0; b_oe_n = 1; a_in = 8'h5A; ab_strobe = 0;
    step();
    ab_strobe = 1;
    step();
    ab_strobe = 0; a_in = 8'h00; b_oe = 1; b_oe_n = 0;
    #1;
    check8("R9 stored while inactive", b_pull, 8'h5A);
    step();

    // R10: A-to-B strobe activity leaves the B-to-A register alone
    ab_mode = 2'b00; ba_mode = 2'b01; loop_en = 0; b_oe = 0; b_oe_n = 1;
    b_ext = 8'h3C; a_in = 8'hFF; ba_strobe = 0; ab_strobe = 0;
    step();
    ab_strobe = 1;
    step();
    ab_strobe = 0; ba_strobe = 1;
    step();
    ba_strobe = 0; b_ext = 8'h00; ab_strobe = 1; ab_mode = 2'b01;
    step();
    ab_strobe = 0;
    #1;
    check8("R10 independent directions", a_out, 8'hC3);
    step();

    // sweep every mode, loopback and enable combination
    for (int cfg = 0; cfg < 256; cfg++) begin
      ab_mode = cfg[1:0]; ba_mode = cfg[3:2]; loop_en = cfg[4];
      a_oe = cfg[5]; b_oe = cfg[6]; b_oe_n = cfg[7];
      for (int k = 0; k < 10; k++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        a_in = lf[7:0]; b_ext = lf[15:8] | {lf[3:0], lf[7:4]};
        ab_strobe = lf[2] ^ lf[9]; ba_strobe = lf[5] ^ lf[11];
        step();
      end
    end
    report();
  end

endmodule